// File: doc/BRIEF.md
# PoE Power Budget Admission Controller

This block decides, cycle by cycle, which of up to eight Power-over-Ethernet ports may carry power. Each port presents a request, a two-bit class and a measured draw. It also raises an overload flag when it trips and an open-circuit flag when its device has been unplugged. The block adds up the measured draw of the ports that are on. It admits a new request only if that total plus the request's class budget stays within 85% of the configured supply. When the measured total rises above the supply, it switches ports off, low-priority ones first.

Configuration arrives as three already-digitized codes with full scale 2^CODE_W-1. The supply code maps linearly onto 0 to 200 W. The high-power code and the priority code each select a count of ports, starting from port 0. A mode input chooses between one port controller (ports 0 to 3 live) and two controllers (ports 0 to 3 on the first, 4 to 7 on the second). All power values are unsigned, in 0.1 W units. Each port shows a registered enable and a three-bit state code.

Top module: `poe_budget_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, every en_o bit is 0 and every state_o field reads 0 (idle).
- R2: The state code per port is 0 idle, 1 on, 2 on at 30 W, 3 denied, 4 fault. Class code 0/1/2/3 budgets 40/70/154/300 tenths of a watt. Let S be the summed meas_i of the ports that are on. A waiting port whose request is chosen is granted only if (S + budget)*FS <= 1700*supply_code_i, with FS = 2^CODE_W-1. Otherwise an idle requester moves to denied.
- R3: Class code 3 on a port that is not high-power is budgeted 154 and granted as state 1. On a high-power port it is budgeted 300 and granted as state 2.
- R4: If S*FS > 2000*supply_code_i, exactly one port per cycle goes to denied and nothing is granted. The victim is the highest-numbered enabled low-priority port or, when none is enabled, the highest-numbered enabled high-priority port.
- R5: If S*FS > 2200*supply_code_i, every enabled low-priority port goes to denied in the same cycle.
- R6: If a high-priority requester does not fit, no high-priority requester fits, and a low-priority port is on, the highest-numbered such low-priority port is denied in that cycle so that the requester can be admitted later.
- R7: An enabled port with ovl_i set enters fault on the next edge and stays there, with en_o low, until open_i is seen on it. It then returns to idle.
- R8: A denied port is granted automatically once its request fits. open_i on any port returns it to idle, overriding every other action.
- R9: With two_ctrl_i high, port i is high-power iff 16*hipwr_code_i >= (2i+1)*FS. With it low, all ports are high-power iff 2*hipwr_code_i > FS. Port i is high-priority iff 16*hiprio_code_i >= (2i+1)*FS in both modes.
- R10: With two_ctrl_i low, ports 4 to 7 stay idle with en_o low whatever their inputs.
- R11: At most one port is granted per cycle. High-priority requesters that fit go before low-priority ones, and the lowest index goes first within a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| two_ctrl_i | input | 1 | 1: two controllers, 8 ports; 0: one controller, 4 ports |
| supply_code_i | input | CODE_W | Supply capacity code, full scale = 200 W |
| hipwr_code_i | input | CODE_W | Code selecting how many ports may take 30 W |
| hiprio_code_i | input | CODE_W | Code selecting how many ports are high priority |
| req_i | input | N_PORTS | Per-port power request |
| class_i | input | 2*N_PORTS | Per-port class code, port i at bits [2i+1:2i] |
| meas_i | input | N_PORTS*PWR_W | Per-port measured draw in 0.1 W, port i at [PWR_W*i +: PWR_W] |
| ovl_i | input | N_PORTS | Per-port overload flag |
| open_i | input | N_PORTS | Per-port open-circuit (unplugged) flag |
| en_o | output | N_PORTS | Per-port power enable |
| state_o | output | 3*N_PORTS | Per-port state code, port i at [3i +: 3] |

## Verification
Every decision lands in the port state registers one edge after the inputs that cause it. A wrong internal choice therefore shows up on state_o and en_o at the very next sample. Examples are a mis-selected shed victim, a grant past the 85% line, or a fault cleared early. The bench runs a reference model alongside the design and compares all eight state codes every cycle. A wrong decision is flagged within one cycle instead of surfacing later as a budget drift. Directed sequences place the totals exactly on the admit, over and severe limits, where an off-by-one compare changes a single port's code.

// File: rtl/poe_budget_pkg.sv
package poe_budget_pkg;
  localparam int ST_W  = 3;
  localparam int BUD_W = 9;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_ON     = 3'd1,
    ST_ON_HI  = 3'd2,
    ST_DENIED = 3'd3,
    ST_FAULT  = 3'd4
  } port_st_e;

  // class budget in 0.1 W; 30 W only on high-power ports
  function automatic logic [BUD_W-1:0] class_budget(input logic [1:0] cls, input logic hp);
    case (cls)
      2'd0:    class_budget = 9'd40;
      2'd1:    class_budget = 9'd70;
      2'd2:    class_budget = 9'd154;
      default: class_budget = hp ? 9'd300 : 9'd154;
    endcase
  endfunction
endpackage

// File: rtl/poe_cfg_decode.sv
module poe_cfg_decode #(
  parameter int N_PORTS = 8,
  parameter int CODE_W  = 8
) (
  input  logic              two_ctrl_i,
  input  logic [CODE_W-1:0] hipwr_code_i,
  input  logic [CODE_W-1:0] hiprio_code_i,
  output logic [N_PORTS-1:0] active_o,
  output logic [N_PORTS-1:0] hipwr_o,
  output logic [N_PORTS-1:0] hiprio_o
);
  localparam int FS   = (1 << CODE_W) - 1;
  localparam int HALF = N_PORTS / 2;
  localparam int DW   = CODE_W + $clog2(N_PORTS) + 4;

  logic half_on;
  assign half_on = (DW'(2) * DW'(hipwr_code_i)) > DW'(FS);

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic hp_rnd, pr_rnd;
    // port g counts if round(N*code/FS) > g
    assign hp_rnd = (DW'(2 * N_PORTS) * DW'(hipwr_code_i))  >= (DW'(2 * g + 1) * DW'(FS));
    assign pr_rnd = (DW'(2 * N_PORTS) * DW'(hiprio_code_i)) >= (DW'(2 * g + 1) * DW'(FS));
    assign hipwr_o[g]  = two_ctrl_i ? hp_rnd : half_on;
    assign hiprio_o[g] = pr_rnd;
    if (g < HALF) begin : g_lo
      assign active_o[g] = 1'b1;
    end else begin : g_hi
      assign active_o[g] = two_ctrl_i;
    end
  end
endmodule

// File: rtl/poe_load_eval.sv
module poe_load_eval
  import poe_budget_pkg::*;
#(
  parameter int N_PORTS  = 8,
  parameter int CODE_W   = 8,
  parameter int PWR_W    = 12,
  parameter int FULL_PWR = 2000
) (
  input  logic [CODE_W-1:0]                supply_code_i,
  input  logic [N_PORTS-1:0]               en_i,
  input  logic [N_PORTS-1:0][PWR_W-1:0]    meas_i,
  input  logic [N_PORTS-1:0][BUD_W-1:0]    bud_i,
  output logic                             over_o,
  output logic                             severe_o,
  output logic [N_PORTS-1:0]               fits_o
);
  localparam int FS       = (1 << CODE_W) - 1;
  localparam int SUM_W    = PWR_W + $clog2(N_PORTS) + 1;
  localparam int CMP_W    = SUM_W + CODE_W + 14;
  localparam int ADMIT_K  = FULL_PWR * 85 / 100;
  localparam int SEVERE_K = FULL_PWR * 11 / 10;

  logic [SUM_W-1:0] sum;
  logic [CMP_W-1:0] sum_fs, lim_admit, lim_over, lim_severe;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_PORTS; i++)
      if (en_i[i]) sum = sum + SUM_W'(meas_i[i]);
  end

  // thresholds scaled by FS so no divide is needed
  assign sum_fs     = CMP_W'(sum) * CMP_W'(FS);
  assign lim_admit  = CMP_W'(ADMIT_K)  * CMP_W'(supply_code_i);
  assign lim_over   = CMP_W'(FULL_PWR) * CMP_W'(supply_code_i);
  assign lim_severe = CMP_W'(SEVERE_K) * CMP_W'(supply_code_i);

  assign over_o   = sum_fs > lim_over;
  assign severe_o = sum_fs > lim_severe;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_fit
    assign fits_o[g] = ((CMP_W'(sum) + CMP_W'(bud_i[g])) * CMP_W'(FS)) <= lim_admit;
  end
endmodule

// File: rtl/poe_port_arbiter.sv
module poe_port_arbiter
  import poe_budget_pkg::*;
#(
  parameter int N_PORTS = 8
) (
  input  logic [N_PORTS-1:0][ST_W-1:0] st_i,
  input  logic [N_PORTS-1:0]           active_i,
  input  logic [N_PORTS-1:0]           hiprio_i,
  input  logic [N_PORTS-1:0]           hi_bud_i,
  input  logic [N_PORTS-1:0]           req_i,
  input  logic [N_PORTS-1:0]           ovl_i,
  input  logic [N_PORTS-1:0]           open_i,
  input  logic [N_PORTS-1:0]           fits_i,
  input  logic                         over_i,
  input  logic                         severe_i,
  output logic [N_PORTS-1:0][ST_W-1:0] st_o
);
  localparam int IDX_W = $clog2(N_PORTS);

  function automatic logic [IDX_W-1:0] first_idx(input logic [N_PORTS-1:0] v);
    first_idx = '0;
    for (int i = N_PORTS - 1; i >= 0; i--)
      if (v[i]) first_idx = IDX_W'(i);
  endfunction

  function automatic logic [IDX_W-1:0] last_idx(input logic [N_PORTS-1:0] v);
    last_idx = '0;
    for (int i = 0; i < N_PORTS; i++)
      if (v[i]) last_idx = IDX_W'(i);
  endfunction

  logic [N_PORTS-1:0] on, elig, reqr, lp_on, hp_on, hp_req, hp_fit, lp_fit;
  logic [IDX_W-1:0]   g_idx, v_idx;

  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      on[i]   = (st_i[i] == ST_ON) || (st_i[i] == ST_ON_HI);
      elig[i] = active_i[i] & on[i] & ~open_i[i] & ~ovl_i[i];
      reqr[i] = active_i[i] & req_i[i] & ~open_i[i] &
                ((st_i[i] == ST_IDLE) || (st_i[i] == ST_DENIED));
    end
  end

  assign lp_on  = elig & ~hiprio_i;
  assign hp_on  = elig & hiprio_i;
  assign hp_req = reqr & hiprio_i;
  assign hp_fit = hp_req & fits_i;
  assign lp_fit = reqr & ~hiprio_i & fits_i;

  always_comb begin
    st_o  = st_i;
    g_idx = '0;
    v_idx = '0;
    if (severe_i && |lp_on) begin
      for (int i = 0; i < N_PORTS; i++)
        if (lp_on[i]) st_o[i] = ST_DENIED;
    end else if (over_i) begin
      if (|lp_on) begin
        v_idx = last_idx(lp_on);
        st_o[v_idx] = ST_DENIED;
      end else if (|hp_on) begin
        v_idx = last_idx(hp_on);
        st_o[v_idx] = ST_DENIED;
      end
    end else begin
      for (int i = 0; i < N_PORTS; i++)
        if (reqr[i] && !fits_i[i] && st_i[i] == ST_IDLE) st_o[i] = ST_DENIED;
      if (|hp_fit) begin
        g_idx = first_idx(hp_fit);
        st_o[g_idx] = hi_bud_i[g_idx] ? ST_ON_HI : ST_ON;
      end else if (|hp_req && |lp_on) begin
        // preempt low priority for a waiting high-priority port
        v_idx = last_idx(lp_on);
        st_o[v_idx] = ST_DENIED;
      end else if (|lp_fit) begin
        g_idx = first_idx(lp_fit);
        st_o[g_idx] = hi_bud_i[g_idx] ? ST_ON_HI : ST_ON;
      end
    end
    // per-port overrides win over shared decisions
    for (int i = 0; i < N_PORTS; i++) begin
      if (!active_i[i] || open_i[i]) st_o[i] = ST_IDLE;
      else if (on[i] && ovl_i[i])    st_o[i] = ST_FAULT;
    end
  end
endmodule

// File: rtl/poe_budget_ctrl.sv
module poe_budget_ctrl
  import poe_budget_pkg::*;
#(
  parameter int N_PORTS  = 8,
  parameter int CODE_W   = 8,
  parameter int PWR_W    = 12,
  parameter int FULL_PWR = 2000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       two_ctrl_i,
  input  logic [CODE_W-1:0]          supply_code_i,
  input  logic [CODE_W-1:0]          hipwr_code_i,
  input  logic [CODE_W-1:0]          hiprio_code_i,
  input  logic [N_PORTS-1:0]         req_i,
  input  logic [2*N_PORTS-1:0]       class_i,
  input  logic [N_PORTS*PWR_W-1:0]   meas_i,
  input  logic [N_PORTS-1:0]         ovl_i,
  input  logic [N_PORTS-1:0]         open_i,
  output logic [N_PORTS-1:0]         en_o,
  output logic [ST_W*N_PORTS-1:0]    state_o
);
  logic [N_PORTS-1:0][ST_W-1:0]  st_q, st_d;
  logic [N_PORTS-1:0][BUD_W-1:0] bud;
  logic [N_PORTS-1:0][PWR_W-1:0] meas;
  logic [N_PORTS-1:0] active, hipwr, hiprio, hi_bud, fits, en_q;
  logic over, severe;

  poe_cfg_decode #(.N_PORTS(N_PORTS), .CODE_W(CODE_W)) i_cfg (
    .two_ctrl_i    (two_ctrl_i),
    .hipwr_code_i  (hipwr_code_i),
    .hiprio_code_i (hiprio_code_i),
    .active_o      (active),
    .hipwr_o       (hipwr),
    .hiprio_o      (hiprio)
  );

  for (genvar g = 0; g < N_PORTS; g++) begin : g_bud
    assign bud[g]    = class_budget(class_i[2*g +: 2], hipwr[g]);
    assign hi_bud[g] = (class_i[2*g +: 2] == 2'd3) && hipwr[g];
    assign meas[g]   = meas_i[PWR_W*g +: PWR_W];
    assign en_o[g]   = (st_q[g] == ST_ON) || (st_q[g] == ST_ON_HI);
  end

  poe_load_eval #(.N_PORTS(N_PORTS), .CODE_W(CODE_W), .PWR_W(PWR_W), .FULL_PWR(FULL_PWR)) i_load (
    .supply_code_i (supply_code_i),
    .en_i          (en_o),
    .meas_i        (meas),
    .bud_i         (bud),
    .over_o        (over),
    .severe_o      (severe),
    .fits_o        (fits)
  );

  poe_port_arbiter #(.N_PORTS(N_PORTS)) i_arb (
    .st_i     (st_q),
    .active_i (active),
    .hiprio_i (hiprio),
    .hi_bud_i (hi_bud),
    .req_i    (req_i),
    .ovl_i    (ovl_i),
    .open_i   (open_i),
    .fits_i   (fits),
    .over_i   (over),
    .severe_i (severe),
    .st_o     (st_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      en_q <= en_o;
    end
  end

  assign state_o = st_q;

  // R11
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_o & ~en_q) <= 1);

  // R4
  over_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over |=> ((en_o & ~en_q) == '0));

  // R5
  severe_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    severe |=> ((en_o & ~$past(hiprio)) == '0));

  for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
    // R7
    fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_FAULT && !open_i[g] && active[g]) |=> (st_q[g] == ST_FAULT));
    // R10
    idle_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active[g] |=> (st_q[g] == ST_IDLE));
  end
endmodule

// File: tb/test_poe_budget_ctrl.sv
module test_poe_budget_ctrl;
  localparam int NP = 8;
  localparam int FS = 255;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        two_ctrl_i;
  logic [7:0]  supply_code_i, hipwr_code_i, hiprio_code_i;
  logic [7:0]  req_i, ovl_i, open_i;
  logic [15:0] class_i;
  logic [95:0] meas_i;
  logic [7:0]  en_o;
  logic [23:0] state_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int m_st[NP];

  poe_budget_ctrl i_poe_budget_ctrl (
    .clk_i, .rst_ni, .two_ctrl_i, .supply_code_i, .hipwr_code_i, .hiprio_code_i,
    .req_i, .class_i, .meas_i, .ovl_i, .open_i, .en_o, .state_o
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int bud(int cls, bit hp);
    case (cls)
      0: return 40;
      1: return 70;
      2: return 154;
      default: return hp ? 300 : 154;
    endcase
  endfunction

  function automatic bit is_hp(int i);
    if (two_ctrl_i) return 16 * int'(hipwr_code_i) >= (2 * i + 1) * FS;
    return 2 * int'(hipwr_code_i) > FS;
  endfunction

  function automatic bit is_pri(int i);
    return 16 * int'(hiprio_code_i) >= (2 * i + 1) * FS;
  endfunction

  function automatic bit is_act(int i);
    return two_ctrl_i || i < 4;
  endfunction

  function automatic bit is_on(int s);
    return s == 1 || s == 2;
  endfunction

  // reference next-state from the requirements
  task automatic model_step();
    int nx[NP];
    longint sum = 0, sup;
    bit over, sev;
    bit elig[NP], rq[NP], fit[NP];
    int b[NP];
    bit any_lp = 0, any_hp = 0, any_hpreq = 0;
    int last_lp = -1, last_hp = -1, g_hp = -1, g_lp = -1;
    sup = longint'(supply_code_i);
    for (int i = 0; i < NP; i++) if (is_on(m_st[i])) sum += longint'(meas_i[12*i +: 12]);
    over = sum * FS > 2000 * sup;
    sev  = sum * FS > 2200 * sup;
    for (int i = 0; i < NP; i++) begin
      nx[i] = m_st[i];
      b[i] = bud(int'(class_i[2*i +: 2]), is_hp(i));
      fit[i] = (sum + b[i]) * FS <= 1700 * sup;
      elig[i] = is_act(i) && is_on(m_st[i]) && !open_i[i] && !ovl_i[i];
      rq[i] = is_act(i) && req_i[i] && !open_i[i] && (m_st[i] == 0 || m_st[i] == 3);
      if (elig[i] && !is_pri(i)) begin any_lp = 1; last_lp = i; end
      if (elig[i] && is_pri(i))  begin any_hp = 1; last_hp = i; end
      if (rq[i] && is_pri(i)) any_hpreq = 1;
    end
    for (int i = NP - 1; i >= 0; i--) begin
      if (rq[i] && fit[i] && is_pri(i))  g_hp = i;
      if (rq[i] && fit[i] && !is_pri(i)) g_lp = i;
    end
    if (sev && any_lp) begin
      for (int i = 0; i < NP; i++) if (elig[i] && !is_pri(i)) nx[i] = 3;
    end else if (over) begin
      if (any_lp) nx[last_lp] = 3;
      else if (any_hp) nx[last_hp] = 3;
    end else begin
      for (int i = 0; i < NP; i++) if (rq[i] && !fit[i] && m_st[i] == 0) nx[i] = 3;
      if (g_hp >= 0) nx[g_hp] = (b[g_hp] == 300) ? 2 : 1;
      else if (any_hpreq && any_lp) nx[last_lp] = 3;
      else if (g_lp >= 0) nx[g_lp] = (b[g_lp] == 300) ? 2 : 1;
    end
    for (int i = 0; i < NP; i++) begin
      if (!is_act(i) || open_i[i]) nx[i] = 0;
      else if (is_on(m_st[i]) && ovl_i[i]) nx[i] = 4;
    end
    m_st = nx;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(string tag, int p, int exp);
    n_chk++;
    if (state_o[3*p +: 3] !== 3'(exp) || en_o[p] !== is_on(exp)) begin
      n_fail++;
      $display("FAIL %s port %0d: actual state %0d en %0b expected state %0d en %0b",
               tag, p, state_o[3*p +: 3], en_o[p], exp, is_on(exp));
    end
  endtask

  task automatic set_meas(int p, int v);
    meas_i[12*p +: 12] = 12'(v);
  endtask

  task automatic set_req(int p, int cls);
    req_i[p] = 1'b1;
    class_i[2*p +: 2] = 2'(cls);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    two_ctrl_i = 1'b1; supply_code_i = 8'd255; hipwr_code_i = '0; hiprio_code_i = 8'd128;
    req_i = '0; ovl_i = '0; open_i = '0; class_i = '0; meas_i = '0;
    for (int i = 0; i < NP; i++) m_st[i] = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    rst_ni = 1'b0;
    void'($urandom(32'd4242));
    do_reset();
    for (int i = 0; i < NP; i++) chk("R1 reset", i, 0);

    // ports 0..3 high priority (code 128), none high-power yet
    set_req(0, 3); step(); chk("R3 capped class 3", 0, 1);
    hipwr_code_i = 8'd255;
    set_req(1, 3); step(); chk("R3 30W grant", 1, 2);
    set_meas(0, 1000); set_meas(1, 400);
    set_req(2, 3); step(); chk("R2 admit at limit", 2, 2);
    set_meas(2, 1); set_req(3, 3); step(); chk("R2 deny above limit", 3, 3);
    set_meas(2, 0); step(); chk("R8 auto grant", 3, 2);
    set_meas(0, 1500); set_req(4, 0); step(); chk("R2 deny low class", 4, 3);
    open_i[4] = 1'b1; step(); chk("R8 unplug denied", 4, 0);
    open_i[4] = 1'b0; req_i[4] = 1'b0;
    ovl_i[1] = 1'b1; step(); chk("R7 fault entry", 1, 4);
    ovl_i[1] = 1'b0; step(); chk("R7 fault held", 1, 4);
    open_i[1] = 1'b1; step(); chk("R7 fault cleared", 1, 0);
    open_i[1] = 1'b0; req_i[1] = 1'b0;

    do_reset();
    hipwr_code_i = 8'd255;
    set_req(0, 0); set_req(1, 0); set_req(4, 0); set_req(5, 0);
    step(); chk("R11 first hp", 0, 1); chk("R11 one per cycle", 1, 0); chk("R11 lp waits", 4, 0);
    step(); chk("R11 second hp", 1, 1);
    step(); chk("R11 lowest lp", 4, 1); chk("R11 lp wait", 5, 0);
    step(); chk("R11 last lp", 5, 1);
    set_meas(0, 400); set_meas(1, 200); set_meas(4, 500); set_meas(5, 1000); req_i[5] = 1'b0;
    step(); chk("R4 shed highest lp", 5, 3); chk("R4 keep lp", 4, 1);
    set_req(6, 0); step(); chk("R11 regrant", 6, 1);
    set_meas(0, 1000); set_meas(4, 600); set_meas(6, 700); req_i[4] = 1'b0; req_i[6] = 1'b0;
    step(); chk("R5 drop lp", 4, 3); chk("R5 drop lp", 6, 3); chk("R5 keep hp", 0, 1); chk("R5 keep hp", 1, 1);
    set_meas(0, 1900); req_i[1] = 1'b0;
    step(); chk("R4 shed hp when no lp", 1, 3); chk("R4 keep hp", 0, 1);
    set_meas(0, 1000); set_req(7, 0); step(); chk("R6 lp granted", 7, 1);
    set_meas(7, 500); set_req(2, 3); req_i[7] = 1'b0;
    step(); chk("R6 preempt lp", 7, 3); chk("R6 hp waits", 2, 3);
    step(); chk("R6 hp admitted", 2, 2);

    do_reset();
    two_ctrl_i = 1'b0; hipwr_code_i = 8'd128; hiprio_code_i = '0;
    set_req(0, 3); set_req(5, 0); set_meas(5, 100);
    step(); chk("R9 4-port above half", 0, 2);
    step(); chk("R10 inactive port", 5, 0);
    hipwr_code_i = 8'd127; set_req(1, 3);
    step(); chk("R9 4-port at half", 1, 1);

    do_reset();
    hipwr_code_i = 8'd16; hiprio_code_i = '0;
    set_req(0, 3); step(); chk("R9 rounding first", 0, 2);
    set_req(1, 3); step(); chk("R9 rounding second", 1, 1);

    // constrained random against the model
    do_reset();
    for (int c = 0; c < 6000; c++) begin
      bit bad = 0;
      if (c % 300 == 0) begin
        two_ctrl_i = ($urandom % 4) != 0;
        supply_code_i = 8'(64 + $urandom % 192);
        hipwr_code_i = 8'($urandom % 256);
        hiprio_code_i = 8'($urandom % 256);
      end
      if (c > 0) begin
        n_chk++;
        for (int i = 0; i < NP; i++)
          if (state_o[3*i +: 3] !== 3'(m_st[i]) || en_o[i] !== is_on(m_st[i])) bad = 1;
        if (bad) begin
          n_fail++;
          $display("FAIL random R2 R4 R5 R6 R7 R8 cycle %0d: actual %h expected %0d%0d%0d%0d%0d%0d%0d%0d",
                   c, state_o, m_st[7], m_st[6], m_st[5], m_st[4], m_st[3], m_st[2], m_st[1], m_st[0]);
        end
      end
      for (int i = 0; i < NP; i++) begin
        req_i[i] = ($urandom % 4) != 0;
        class_i[2*i +: 2] = 2'($urandom % 4);
        set_meas(i, int'($urandom % 320));
        ovl_i[i] = ($urandom % 64) == 0;
        open_i[i] = ($urandom % 32) == 0;
      end
      model_step();
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule